// File: doc/BRIEF.md
# Hot-Plug Slot Insertion and Removal Event Handler

This block turns slot-side physical events into updates of a hot-plug controller's per-slot status and event latch. A single strobe announces that a device was inserted, with a flag marking whether the insertion was already there when the system came up. A separate strobe asks for a device to be removed. Each strobe names a slot by its 1-based slot number. The block reads the current retention-latch, slot-state and power-indicator values of that slot from the slot register file around it. One cycle later it issues a single registered update record. The record carries write enables and values for the latch-open bit and the presence field, a clear for the 66 MHz capable bit, a set mask for the event latch, a completion pulse that frees the slot, and an error pulse.

The same strobe can mean different things depending on the slot's state. An insertion on a slot whose latch is open is a fresh arrival. An insertion on a slot whose latch is closed stands in for an attention-button press, which cancels a pending removal. A removal request only completes when software has already disabled the slot and turned its power indicator off. Otherwise the request is passed on as a button press, so that software can start the orderly shutdown. Command decoding and interrupt generation sit in neighbouring blocks, and the interrupt block uses the event strobe to re-evaluate its inputs.

Top module: `hp_slot_event`

## Requirements
- R1: A strobe whose slot number is 0 or greater than NSLOTS produces `slot_err` for one cycle, one cycle after the strobe, with `upd_vld`, every write enable, `clr_66`, `evt_set` and `slot_free` all low.
- R2: An insertion with `ins_boot` high writes latch-open to 0 and presence to 0 (7.5 W). It sets no event bit and does not clear the 66 MHz bit.
- R3: An insertion with `ins_boot` low on a slot whose latch is open writes latch-open to 0 and presence to 0. It sets the event mask to 3'b111.
- R4: An insertion with `ins_boot` low on a slot whose latch is closed writes neither latch-open nor presence. It sets only the button event (`evt_set` = 3'b100).
- R5: A removal request on a slot whose state is disabled (2'b11) and whose power indicator is off (2'b11) pulses `slot_free`. It writes latch-open to 1 and presence to 3 (empty), and sets `evt_set` = 3'b011.
- R6: A removal request in any other combination of state and power indicator writes neither latch-open nor presence, does not pulse `slot_free`, and sets only the button event.
- R7: Every runtime insertion and every removal request to a valid slot pulses `clr_66`. A power-up insertion does not.
- R8: Presence values use a 2-bit code: 3 = empty, 1 = 25 W, 2 = 15 W, 0 = 7.5 W. The event mask bits are [0] presence changed, [1] latch changed and [2] attention button.
- R9: `evt_stb` is high for exactly the one cycle in which `evt_set` is non-zero, and it is low in the following cycle unless a new strobe arrives.
- R10: All outputs are registered and appear one cycle after the strobe. When both strobes arrive in the same cycle, the insertion is handled and the removal request is dropped.
- R11: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_stb | input | 1 | Device insertion strobe |
| ins_boot | input | 1 | Insertion was present at power-up |
| rem_stb | input | 1 | Removal request strobe |
| slot_num | input | SLOT_W | 1-based slot number of the event |
| slot_latch_open | input | NSLOTS | Current latch-open bit per slot (bit i = slot i+1) |
| slot_state | input | 2*NSLOTS | Current slot state per slot, 2 bits each |
| slot_pwr_led | input | 2*NSLOTS | Current power indicator per slot, 2 bits each |
| upd_vld | output | 1 | Update record valid |
| upd_slot | output | SLOT_W | Slot number the update applies to |
| latch_we | output | 1 | Write enable for latch-open |
| latch_val | output | 1 | New latch-open value |
| pres_we | output | 1 | Write enable for presence field |
| pres_val | output | 2 | New presence code |
| clr_66 | output | 1 | Clear the slot's 66 MHz capable bit |
| evt_set | output | 3 | Event latch bits to set |
| evt_stb | output | 1 | Event latch changed, interrupt re-evaluation |
| slot_free | output | 1 | Removal completed, slot may be freed |
| slot_err | output | 1 | Slot number out of range |

## Verification
Insertions are tried both with the power-up flag set and with it clear, and on slots whose latch is open and slots whose latch is closed. This separates the silent boot path, the fresh-arrival path and the button-cancel path. Removal requests are tried on a slot that is disabled with its indicator off, and on slots that are disabled with the indicator on or enabled with it off. This shows that only the exact combination completes a removal. Slot numbers 0, 1, NSLOTS and NSLOTS+1 probe both edges of the range check. A cycle with both strobes together shows that insertion takes priority.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;

  localparam logic [1:0] ST_NONE     = 2'b00;
  localparam logic [1:0] ST_PWRONLY  = 2'b01;
  localparam logic [1:0] ST_ENABLED  = 2'b10;
  localparam logic [1:0] ST_DISABLED = 2'b11;

  localparam logic [1:0] LED_KEEP  = 2'b00;
  localparam logic [1:0] LED_ON    = 2'b01;
  localparam logic [1:0] LED_BLINK = 2'b10;
  localparam logic [1:0] LED_OFF   = 2'b11;

  localparam logic [1:0] PRES_7W5  = 2'b00;
  localparam logic [1:0] PRES_25W  = 2'b01;
  localparam logic [1:0] PRES_15W  = 2'b10;
  localparam logic [1:0] PRES_NONE = 2'b11;

  localparam int EVT_W     = 3;
  localparam int EVT_PRES  = 0;
  localparam int EVT_LATCH = 1;
  localparam int EVT_BTN   = 2;

  typedef struct packed {
    logic             vld;
    logic             latch_we;
    logic             latch_val;
    logic             pres_we;
    logic [1:0]       pres_val;
    logic             clr66;
    logic [EVT_W-1:0] evt;
    logic             free;
    logic             err;
  } hp_upd_t;

endpackage

// File: rtl/hp_slot_pick.sv
module hp_slot_pick #(
  parameter int NSLOTS = 6,
  parameter int SLOT_W = 3
) (
  input  logic [SLOT_W-1:0]   slot_num,
  input  logic [NSLOTS-1:0]   latch_vec,
  input  logic [2*NSLOTS-1:0] state_vec,
  input  logic [2*NSLOTS-1:0] led_vec,
  output logic                in_range,
  output logic                latch_open,
  output logic [1:0]          state,
  output logic [1:0]          led
);

  logic [NSLOTS-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NSLOTS; g++) begin : g_hit
      assign hit[g] = (slot_num == SLOT_W'(g + 1));
    end
  endgenerate

  assign in_range = |hit;

  always_comb begin
    latch_open = 1'b0;
    state      = 2'b00;
    led        = 2'b00;
    for (int i = 0; i < NSLOTS; i++) begin
      latch_open = latch_open | (hit[i] & latch_vec[i]);
      state      = state | ({2{hit[i]}} & state_vec[2*i +: 2]);
      led        = led   | ({2{hit[i]}} & led_vec[2*i +: 2]);
    end
  end

endmodule

// File: rtl/hp_event_rules.sv
module hp_event_rules
  import hp_evt_pkg::*;
(
  input  logic       ins_stb,
  input  logic       ins_boot,
  input  logic       rem_stb,
  input  logic       in_range,
  input  logic       latch_open,
  input  logic [1:0] state,
  input  logic [1:0] led,
  output hp_upd_t    upd
);

  logic [EVT_W-1:0] evt_arrive;
  logic [EVT_W-1:0] evt_leave;
  logic [EVT_W-1:0] evt_button;

  always_comb begin
    evt_arrive = '0;
    evt_arrive[EVT_PRES]  = 1'b1;
    evt_arrive[EVT_LATCH] = 1'b1;
    evt_arrive[EVT_BTN]   = 1'b1;
    evt_leave = '0;
    evt_leave[EVT_PRES]   = 1'b1;
    evt_leave[EVT_LATCH]  = 1'b1;
    evt_button = '0;
    evt_button[EVT_BTN]   = 1'b1;
  end

  always_comb begin
    upd = '0;
    if (ins_stb || rem_stb) begin
      if (!in_range) begin
        upd.err = 1'b1;
      end else begin
        upd.vld = 1'b1;
        if (ins_stb) begin
          if (ins_boot) begin
            upd.latch_we  = 1'b1;
            upd.latch_val = 1'b0;
            upd.pres_we   = 1'b1;
            upd.pres_val  = PRES_7W5;
          end else if (latch_open) begin
            upd.latch_we  = 1'b1;
            upd.latch_val = 1'b0;
            upd.pres_we   = 1'b1;
            upd.pres_val  = PRES_7W5;
            upd.evt       = evt_arrive;
            upd.clr66     = 1'b1;
          end else begin
            upd.evt   = evt_button;
            upd.clr66 = 1'b1;
          end
        end else begin
          upd.clr66 = 1'b1;
          if (state == ST_DISABLED && led == LED_OFF) begin
            upd.free      = 1'b1;
            upd.latch_we  = 1'b1;
            upd.latch_val = 1'b1;
            upd.pres_we   = 1'b1;
            upd.pres_val  = PRES_NONE;
            upd.evt       = evt_leave;
          end else begin
            upd.evt = evt_button;
          end
        end
      end
    end
  end

endmodule

// File: rtl/hp_slot_event.sv
module hp_slot_event
  import hp_evt_pkg::*;
#(
  parameter int NSLOTS = 6,
  parameter int SLOT_W = $clog2(NSLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_stb,
  input  logic                ins_boot,
  input  logic                rem_stb,
  input  logic [SLOT_W-1:0]   slot_num,
  input  logic [NSLOTS-1:0]   slot_latch_open,
  input  logic [2*NSLOTS-1:0] slot_state,
  input  logic [2*NSLOTS-1:0] slot_pwr_led,
  output logic                upd_vld,
  output logic [SLOT_W-1:0]   upd_slot,
  output logic                latch_we,
  output logic                latch_val,
  output logic                pres_we,
  output logic [1:0]          pres_val,
  output logic                clr_66,
  output logic [2:0]          evt_set,
  output logic                evt_stb,
  output logic                slot_free,
  output logic                slot_err
);

  logic       sel_in_range;
  logic       sel_latch;
  logic [1:0] sel_state;
  logic [1:0] sel_led;
  hp_upd_t    upd_d;
  hp_upd_t    upd_q;
  logic [SLOT_W-1:0] slot_d;
  logic [SLOT_W-1:0] slot_q;
  logic       stb_d;
  logic       stb_q;
  logic       slot_en;

  hp_slot_pick #(
    .NSLOTS (NSLOTS),
    .SLOT_W (SLOT_W)
  ) i_pick (
    .slot_num   (slot_num),
    .latch_vec  (slot_latch_open),
    .state_vec  (slot_state),
    .led_vec    (slot_pwr_led),
    .in_range   (sel_in_range),
    .latch_open (sel_latch),
    .state      (sel_state),
    .led        (sel_led)
  );

  hp_event_rules i_rules (
    .ins_stb    (ins_stb),
    .ins_boot   (ins_boot),
    .rem_stb    (rem_stb),
    .in_range   (sel_in_range),
    .latch_open (sel_latch),
    .state      (sel_state),
    .led        (sel_led),
    .upd        (upd_d)
  );

  // next-state
  always_comb begin
    slot_en = upd_d.vld | upd_q.vld;
    slot_d  = upd_d.vld ? slot_num : '0;
    stb_d   = |upd_d.evt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= '0;
      stb_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (slot_en) begin
      slot_q <= slot_d;
    end
  end

  assign upd_vld   = upd_q.vld;
  assign upd_slot  = slot_q;
  assign latch_we  = upd_q.latch_we;
  assign latch_val = upd_q.latch_val;
  assign pres_we   = upd_q.pres_we;
  assign pres_val  = upd_q.pres_val;
  assign clr_66    = upd_q.clr66;
  assign evt_set   = upd_q.evt;
  assign evt_stb   = stb_q;
  assign slot_free = upd_q.free;
  assign slot_err  = upd_q.err;

  AST_BAD_SLOT_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((ins_stb || rem_stb) && (slot_num == '0 || int'(slot_num) > NSLOTS))
      |=> (slot_err && !upd_vld && !latch_we && !pres_we && evt_set == '0)); // R1

  AST_BOOT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_stb && ins_boot && slot_num != '0 && int'(slot_num) <= NSLOTS)
      |=> (upd_vld && !evt_stb && !clr_66 && pres_val == PRES_7W5)); // R2

  AST_FREE_NEEDS_REMOVAL: assert property (@(posedge clk) disable iff (!rst_n)
    slot_free |-> ($past(rem_stb) && !$past(ins_stb) && pres_val == PRES_NONE && latch_val)); // R5

  AST_EVT_STROBE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |-> (evt_set != '0)); // R9

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_err && upd_vld)); // R1

  AST_INSERT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_stb && rem_stb) |=> !slot_free); // R10

endmodule

// File: tb/test_hp_slot_event.sv
module test_hp_slot_event;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOTS = 6;
  localparam int SLOT_W = $clog2(NSLOTS + 1);

  logic                clk;
  logic                rst_n;
  logic                ins_stb;
  logic                ins_boot;
  logic                rem_stb;
  logic [SLOT_W-1:0]   slot_num;
  logic [NSLOTS-1:0]   slot_latch_open;
  logic [2*NSLOTS-1:0] slot_state;
  logic [2*NSLOTS-1:0] slot_pwr_led;
  logic                upd_vld;
  logic [SLOT_W-1:0]   upd_slot;
  logic                latch_we;
  logic                latch_val;
  logic                pres_we;
  logic [1:0]          pres_val;
  logic                clr_66;
  logic [2:0]          evt_set;
  logic                evt_stb;
  logic                slot_free;
  logic                slot_err;

  int checks;
  int errors;

  hp_slot_event #(.NSLOTS(NSLOTS)) i_hp_slot_event (
    .clk             (clk),
    .rst_n           (rst_n),
    .ins_stb         (ins_stb),
    .ins_boot        (ins_boot),
    .rem_stb         (rem_stb),
    .slot_num        (slot_num),
    .slot_latch_open (slot_latch_open),
    .slot_state      (slot_state),
    .slot_pwr_led    (slot_pwr_led),
    .upd_vld         (upd_vld),
    .upd_slot        (upd_slot),
    .latch_we        (latch_we),
    .latch_val       (latch_val),
    .pres_we         (pres_we),
    .pres_val        (pres_val),
    .clr_66          (clr_66),
    .evt_set         (evt_set),
    .evt_stb         (evt_stb),
    .slot_free       (slot_free),
    .slot_err        (slot_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // Compare the whole update record against expected field values.
  task automatic check_rec(input string req, input int vld, input int we_l, input int v_l,
                           input int we_p, input int v_p, input int c66, input int ev,
                           input int fr, input int er);
    check(req, "upd_vld", int'(upd_vld), vld);
    check(req, "latch_we", int'(latch_we), we_l);
    if (we_l != 0) check(req, "latch_val", int'(latch_val), v_l);
    check(req, "pres_we", int'(pres_we), we_p);
    if (we_p != 0) check(req, "pres_val", int'(pres_val), v_p);
    check(req, "clr_66", int'(clr_66), c66);
    check(req, "evt_set", int'(evt_set), ev);
    check(req, "evt_stb", int'(evt_stb), (ev != 0) ? 1 : 0);
    check(req, "slot_free", int'(slot_free), fr);
    check(req, "slot_err", int'(slot_err), er);
  endtask

  task automatic set_slot(input int n, input logic lo, input logic [1:0] st, input logic [1:0] led);
    slot_latch_open[n-1]   = lo;
    slot_state[2*(n-1) +: 2]   = st;
    slot_pwr_led[2*(n-1) +: 2] = led;
  endtask

  // Strobe for one cycle; return at the negedge after the capturing edge.
  task automatic fire(input logic ins, input logic boot, input logic rem, input int sn);
    @(negedge clk);
    ins_stb  = ins;
    ins_boot = boot;
    rem_stb  = rem;
    slot_num = SLOT_W'(sn);
    @(negedge clk);
    ins_stb  = 1'b0;
    ins_boot = 1'b0;
    rem_stb  = 1'b0;
  endtask

  task automatic t_reset();
    check_rec("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R11", "upd_slot", int'(upd_slot), 0);
  endtask

  task automatic t_range();
    fire(1'b1, 1'b0, 1'b0, 0);
    check_rec("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    fire(1'b0, 1'b0, 1'b1, NSLOTS + 1);
    check_rec("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_boot_insert();
    set_slot(1, 1'b1, 2'b11, 2'b11);
    fire(1'b1, 1'b1, 1'b0, 1);
    check_rec("R2", 1, 1, 0, 1, 0, 0, 0, 0, 0);
    check("R2", "upd_slot", int'(upd_slot), 1);
  endtask

  task automatic t_arrival();
    set_slot(2, 1'b1, 2'b11, 2'b11);
    fire(1'b1, 1'b0, 1'b0, 2);
    check_rec("R3", 1, 1, 0, 1, 0, 1, 7, 0, 0);
    check("R7", "clr_66 arrival", int'(clr_66), 1);
    check("R3", "upd_slot", int'(upd_slot), 2);
    @(negedge clk);
    check("R9", "evt_stb after pulse", int'(evt_stb), 0);
    check("R9", "evt_set after pulse", int'(evt_set), 0);
  endtask

  task automatic t_cancel();
    set_slot(3, 1'b0, 2'b10, 2'b10);
    fire(1'b1, 1'b0, 1'b0, 3);
    check_rec("R4", 1, 0, 0, 0, 0, 1, 4, 0, 0);
  endtask

  task automatic t_remove_done();
    set_slot(NSLOTS, 1'b0, 2'b11, 2'b11);
    fire(1'b0, 1'b0, 1'b1, NSLOTS);
    check_rec("R5", 1, 1, 1, 1, 3, 1, 3, 1, 0);
    check("R8", "empty presence code", int'(pres_val), 3);
    check("R5", "upd_slot", int'(upd_slot), NSLOTS);
  endtask

  task automatic t_remove_pending();
    set_slot(4, 1'b0, 2'b11, 2'b01);
    fire(1'b0, 1'b0, 1'b1, 4);
    check_rec("R6", 1, 0, 0, 0, 0, 1, 4, 0, 0);
    set_slot(5, 1'b0, 2'b10, 2'b11);
    fire(1'b0, 1'b0, 1'b1, 5);
    check_rec("R6", 1, 0, 0, 0, 0, 1, 4, 0, 0);
  endtask

  task automatic t_both();
    set_slot(2, 1'b0, 2'b11, 2'b11);
    fire(1'b1, 1'b0, 1'b1, 2);
    check_rec("R10", 1, 0, 0, 0, 0, 1, 4, 0, 0);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    ins_stb = 1'b0;
    ins_boot = 1'b0;
    rem_stb = 1'b0;
    slot_num = '0;
    slot_latch_open = '1;
    slot_state = '1;
    slot_pwr_led = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_range();
    t_boot_insert();
    t_arrival();
    t_cancel();
    t_remove_done();
    t_remove_pending();
    t_both();
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule